// File: doc/BRIEF.md
# SONET Line Defect Monitor

This block follows the receive line overhead of a SONET/SDH stream one frame at a time. Once per frame it takes the low three bits of the K2 byte, the out-of-frame flag from the framer and the raw loss-of-signal pin. From these it keeps four outputs: line alarm indication (LAIS), line remote defect detected (LRDI), loss of frame (LOF), and a request to the transmit side to send remote defect indication.

The K2 monitors change state only after a K2 class has been seen on a programmable number of consecutive frames. This count applies both to declaring a defect and to clearing it. LOF is declared after a fixed run of out-of-frame frames. It clears after a run of in-frame frames, and that run is 8 or 24 frames long, chosen by a control bit. The loss-of-signal input has a programmable polarity, and it can be masked from the transmit RDI request.

All state changes only on the frame strobe. A synchronous reset clears all state.

Top module: `line_defect_mon`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs are 0 after that edge, and all run counts start again from zero.
- R2: A frame's K2 class comes from `k2Code`. The value 3'b111 is the AIS class, 3'b110 is the RDI class, and every other value is the idle class.
- R3: If the current frame's class matches the class of the previous frame, the run length goes up by one, saturating at 15. Otherwise the run length becomes 1. When the run length reaches the threshold, `laisOut` becomes (class == AIS) and `lrdiOut` becomes (class == RDI). Below the threshold both keep their values.
- R4: The threshold is `persistCnt`. A `persistCnt` of 0 acts as 1, so a single frame is enough to change the monitors.
- R5: `lofOut` goes to 1 on the 24th consecutive frame with `oofIn` high. A frame with `oofIn` low resets the run of out-of-frame frames.
- R6: While LOF is set, `lofOut` goes to 0 after 8 consecutive frames with `oofIn` low when `lofFastClr`=1, or after 24 such frames when `lofFastClr`=0. A frame with `oofIn` high resets this clear run.
- R7: Loss of signal counts as active when `losPin` XOR `losActLow` is 1. So `losActLow`=1 means the pin is active low.
- R8: When `losInh`=1, an active loss of signal does not contribute to `rdiReq`.
- R9: After each frame, `rdiReq` equals `laisOut` OR `lofOut` OR (active loss of signal AND NOT `losInh`), using the values sampled with that frame.
- R10: In a cycle with `frameStb` low, none of the outputs change, whatever the other inputs do.
- R11: `laisOut` and `lrdiOut` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frameStb | input | 1 | One-cycle pulse per received frame |
| k2Code | input | 3 | K2 bits 2..0 of the current frame |
| oofIn | input | 1 | Out-of-frame flag from the framer |
| losPin | input | 1 | Raw loss-of-signal indication |
| persistCnt | input | 4 | Consecutive-frame threshold for the K2 monitors |
| losActLow | input | 1 | 1: `losPin` is active low |
| losInh | input | 1 | 1: loss of signal is masked from `rdiReq` |
| lofFastClr | input | 1 | 1: 8-frame LOF clear window, 0: 24-frame window |
| laisOut | output | 1 | Line AIS detected |
| lrdiOut | output | 1 | Line RDI detected |
| lofOut | output | 1 | Loss of frame |
| rdiReq | output | 1 | Request to send RDI on the transmit side |

## Verification
The assertions assume that `frameStb` is a pulse sampled once per edge. They also assume that the control inputs and `oofIn` are valid whenever the strobe is high. Nothing is assumed about these inputs between strobes, because every state change is gated by the strobe.

The stimulus drives each frame's inputs together with the strobe on a falling edge and lowers the strobe one cycle later. In the hold test it changes the inputs freely while the strobe is low, which checks that the outputs ignore those changes.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

  typedef enum logic [1:0] {
    K2_IDLE = 2'd0,
    K2_AIS  = 2'd1,
    K2_RDI  = 2'd2
  } k2Cls_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   tick;      // frame strobe
    logic   sameRun;   // class equals previous frame's class
    logic   k2Commit;  // run has reached threshold this frame
    k2Cls_e cls;       // class of this frame
    logic   oofNow;    // out-of-frame this frame
    logic   lofSet;    // declare LOF
    logic   lofClr;    // clear LOF
    logic   losReq;    // polarity-corrected, unmasked LOS
  } ldmStb_t;

endpackage

// File: rtl/ldm_ctrl.sv
module ldm_ctrl
  import ldm_pkg::*;
#(
  parameter int RUN_W    = 4,
  parameter int CNT_W    = 5,
  parameter int OOF_SET  = 24,
  parameter int CLR_FAST = 8,
  parameter int CLR_SLOW = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frameStb,
  input  logic [2:0]       k2Code,
  input  logic             oofIn,
  input  logic             losPin,
  input  logic [RUN_W-1:0] persistCnt,
  input  logic             losActLow,
  input  logic             losInh,
  input  logic             lofFastClr,
  input  k2Cls_e           lastCls,
  input  logic [RUN_W-1:0] runCnt,
  input  logic [CNT_W-1:0] oofCnt,
  input  logic [CNT_W-1:0] clrCnt,
  input  logic             lofState,
  output ldmStb_t          stb
);

  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);
  localparam logic [CNT_W:0]   SET_LIM = (CNT_W+1)'(OOF_SET);
  localparam logic [CNT_W:0]   FAST_LIM = (CNT_W+1)'(CLR_FAST);
  localparam logic [CNT_W:0]   SLOW_LIM = (CNT_W+1)'(CLR_SLOW);

  k2Cls_e           cls;
  logic [RUN_W-1:0] thr;
  logic [RUN_W-1:0] runNext;
  logic             sameRun;
  logic [CNT_W:0]   oofInc;
  logic [CNT_W:0]   clrInc;
  logic [CNT_W:0]   clrWin;
  logic             losAct;

  always_comb begin
    unique case (k2Code)
      3'b111:  cls = K2_AIS;
      3'b110:  cls = K2_RDI;
      default: cls = K2_IDLE;
    endcase
  end

  always_comb begin
    thr     = (persistCnt == '0) ? RUN_ONE : persistCnt;
    sameRun = (cls == lastCls);
    if (!sameRun)              runNext = RUN_ONE;
    else if (runCnt == RUN_MAX) runNext = runCnt;
    else                        runNext = runCnt + RUN_ONE;
  end

  always_comb begin
    oofInc = {1'b0, oofCnt} + 1'b1;
    clrInc = {1'b0, clrCnt} + 1'b1;
    clrWin = lofFastClr ? FAST_LIM : SLOW_LIM;
    losAct = losPin ^ losActLow;
  end

  always_comb begin
    stb.tick     = frameStb;
    stb.sameRun  = sameRun;
    stb.cls      = cls;
    stb.k2Commit = frameStb && (runNext >= thr);
    stb.oofNow   = oofIn;
    stb.lofSet   = frameStb && oofIn && !lofState && (oofInc >= SET_LIM);
    stb.lofClr   = frameStb && !oofIn && lofState && (clrInc >= clrWin);
    stb.losReq   = losAct && !losInh;
  end

  // R4
  single_frame_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.k2Commit && !sameRun) |-> (persistCnt <= RUN_ONE));

  // R6
  clear_needs_inframe_chk: assert property (@(posedge clk) disable iff (rst)
    stb.lofClr |-> (!oofIn && lofState));

endmodule

// File: rtl/ldm_datapath.sv
module ldm_datapath
  import ldm_pkg::*;
#(
  parameter int RUN_W    = 4,
  parameter int CNT_W    = 5,
  parameter int OOF_SET  = 24,
  parameter int CLR_SLOW = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  ldmStb_t          stb,
  output k2Cls_e           lastCls,
  output logic [RUN_W-1:0] runCnt,
  output logic [CNT_W-1:0] oofCnt,
  output logic [CNT_W-1:0] clrCnt,
  output logic             lofState,
  output logic             laisOut,
  output logic             lrdiOut,
  output logic             rdiReq
);

  localparam int NMON = 2;
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);
  localparam logic [CNT_W-1:0] OOF_MAX = CNT_W'(OOF_SET);
  localparam logic [CNT_W-1:0] CLR_MAX = CNT_W'(CLR_SLOW);

  logic [NMON-1:0] defBit;
  logic [NMON-1:0] defNext;
  logic            lofNext;

  // run tracking of the K2 class
  always_ff @(posedge clk) begin
    if (rst) begin
      lastCls <= K2_IDLE;
      runCnt  <= '0;
    end else if (stb.tick) begin
      lastCls <= stb.cls;
      if (!stb.sameRun)           runCnt <= RUN_ONE;
      else if (runCnt != RUN_MAX) runCnt <= runCnt + RUN_ONE;
    end
  end

  // out-of-frame and in-frame run counters
  always_ff @(posedge clk) begin
    if (rst) begin
      oofCnt <= '0;
      clrCnt <= '0;
    end else if (stb.tick) begin
      if (stb.oofNow) begin
        clrCnt <= '0;
        if (oofCnt != OOF_MAX) oofCnt <= oofCnt + 1'b1;
      end else begin
        oofCnt <= '0;
        if (clrCnt != CLR_MAX) clrCnt <= clrCnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (stb.lofSet)      lofNext = 1'b1;
    else if (stb.lofClr) lofNext = 1'b0;
    else                 lofNext = lofState;
  end

  always_ff @(posedge clk) begin
    if (rst)           lofState <= 1'b0;
    else if (stb.tick) lofState <= lofNext;
  end

  // one monitor per K2 defect class
  for (genvar i = 0; i < NMON; i++) begin : g_mon
    localparam k2Cls_e MY_CLS = (i == 0) ? K2_AIS : K2_RDI;
    always_comb begin
      defNext[i] = stb.k2Commit ? (stb.cls == MY_CLS) : defBit[i];
    end
    always_ff @(posedge clk) begin
      if (rst)           defBit[i] <= 1'b0;
      else if (stb.tick) defBit[i] <= defNext[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rdiReq <= 1'b0;
    else if (stb.tick) rdiReq <= defNext[0] | lofNext | stb.losReq;
  end

  always_comb begin
    laisOut = defBit[0];
    lrdiOut = defBit[1];
  end

  // R11
  no_dual_defect_chk: assert property (@(posedge clk) disable iff (rst)
    !(laisOut && lrdiOut));

  // R10
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.tick |=> $stable({laisOut, lrdiOut, lofState, rdiReq}));

  // R5
  lof_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lofState) |-> $past(stb.tick && stb.oofNow));

  // R6
  lof_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lofState) |-> $past(stb.tick && !stb.oofNow));

  // R9
  rdi_covers_chk: assert property (@(posedge clk) disable iff (rst)
    (laisOut || lofState) |-> rdiReq);

  // R5
  oof_bound_chk: assert property (@(posedge clk) disable iff (rst)
    oofCnt <= OOF_MAX);

endmodule

// File: rtl/line_defect_mon.sv
module line_defect_mon
  import ldm_pkg::*;
#(
  parameter int RUN_W    = 4,
  parameter int OOF_SET  = 24,
  parameter int CLR_FAST = 8,
  parameter int CLR_SLOW = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frameStb,
  input  logic [2:0]       k2Code,
  input  logic             oofIn,
  input  logic             losPin,
  input  logic [RUN_W-1:0] persistCnt,
  input  logic             losActLow,
  input  logic             losInh,
  input  logic             lofFastClr,
  output logic             laisOut,
  output logic             lrdiOut,
  output logic             lofOut,
  output logic             rdiReq
);

  localparam int CNT_MAX = (OOF_SET > CLR_SLOW) ? OOF_SET : CLR_SLOW;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  ldmStb_t          stb;
  k2Cls_e           lastCls;
  logic [RUN_W-1:0] runCnt;
  logic [CNT_W-1:0] oofCnt;
  logic [CNT_W-1:0] clrCnt;
  logic             lofState;

  ldm_ctrl #(
    .RUN_W(RUN_W), .CNT_W(CNT_W), .OOF_SET(OOF_SET),
    .CLR_FAST(CLR_FAST), .CLR_SLOW(CLR_SLOW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .frameStb(frameStb), .k2Code(k2Code),
    .oofIn(oofIn), .losPin(losPin), .persistCnt(persistCnt),
    .losActLow(losActLow), .losInh(losInh), .lofFastClr(lofFastClr),
    .lastCls(lastCls), .runCnt(runCnt), .oofCnt(oofCnt),
    .clrCnt(clrCnt), .lofState(lofState), .stb(stb)
  );

  ldm_datapath #(
    .RUN_W(RUN_W), .CNT_W(CNT_W), .OOF_SET(OOF_SET), .CLR_SLOW(CLR_SLOW)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .lastCls(lastCls),
    .runCnt(runCnt), .oofCnt(oofCnt), .clrCnt(clrCnt),
    .lofState(lofState), .laisOut(laisOut), .lrdiOut(lrdiOut),
    .rdiReq(rdiReq)
  );

  assign lofOut = lofState;

endmodule

// File: tb/sim_line_defect_mon.sv
module sim_line_defect_mon;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frameStb = 1'b0;
  logic [2:0] k2Code = 3'd0;
  logic       oofIn = 1'b0;
  logic       losPin = 1'b0;
  logic [3:0] persistCnt = 4'd5;
  logic       losActLow = 1'b0;
  logic       losInh = 1'b0;
  logic       lofFastClr = 1'b0;
  logic       laisOut, lrdiOut, lofOut, rdiReq;

  int checks = 0;
  int errors = 0;

  // reference state
  int mLast, mRun, mOof, mClr;
  bit mLais, mLrdi, mLof, mRdi;
  string curTag = "R3";

  always #10 clk = ~clk;

  line_defect_mon u0 (
    .clk(clk), .rst(rst), .frameStb(frameStb), .k2Code(k2Code),
    .oofIn(oofIn), .losPin(losPin), .persistCnt(persistCnt),
    .losActLow(losActLow), .losInh(losInh), .lofFastClr(lofFastClr),
    .laisOut(laisOut), .lrdiOut(lrdiOut), .lofOut(lofOut), .rdiReq(rdiReq)
  );

  task automatic chk(input string tag, input string what, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "laisOut", laisOut, mLais);
    chk(tag, "lrdiOut", lrdiOut, mLrdi);
    chk(tag, "lofOut", lofOut, mLof);
    chk(tag, "rdiReq", rdiReq, mRdi);
    chk("R11", "lais&lrdi", laisOut & lrdiOut, 1'b0);
  endtask

  task automatic modelReset();
    mLast = 0; mRun = 0; mOof = 0; mClr = 0;
    mLais = 0; mLrdi = 0; mLof = 0; mRdi = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    frameStb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
    checkAll("R1");
  endtask

  task automatic frame(input logic [2:0] k2, input bit oof, input bit los);
    int cls, thr, win;
    @(negedge clk);
    k2Code = k2; oofIn = oof; losPin = los; frameStb = 1'b1;
    @(negedge clk);
    frameStb = 1'b0;
    // R2 classification
    cls = (k2 == 3'b111) ? 1 : (k2 == 3'b110) ? 2 : 0;
    // R3 run length
    if (cls == mLast) mRun = (mRun < 15) ? mRun + 1 : 15;
    else mRun = 1;
    mLast = cls;
    // R4 zero threshold acts as one
    thr = (persistCnt == 0) ? 1 : int'(persistCnt);
    if (mRun >= thr) begin
      mLais = (cls == 1);
      mLrdi = (cls == 2);
    end
    // R5 / R6
    win = lofFastClr ? 8 : 24;
    if (oof) begin
      mOof = (mOof < 24) ? mOof + 1 : 24;
      mClr = 0;
      if (mOof >= 24) mLof = 1;
    end else begin
      mOof = 0;
      mClr = (mClr < 24) ? mClr + 1 : 24;
      if (mLof && mClr >= win) mLof = 0;
    end
    // R7 R8 R9
    mRdi = mLais | mLof | ((los ^ losActLow) & ~losInh);
    checkAll(curTag);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    modelReset();
    doReset();

    // R2 R3 R4: every K2 code, several thresholds, runs past threshold
    for (int p = 0; p <= 6; p++) begin
      persistCnt = 4'(p);
      curTag = (p == 0) ? "R4" : "R2";
      for (int c = 0; c < 8; c++)
        for (int n = 0; n < p + 2; n++) frame(3'(c), 1'b0, 1'b0);
      curTag = "R3";
      for (int n = 0; n < p + 1; n++) frame(3'b111, 1'b0, 1'b0);
      for (int n = 0; n < p + 1; n++) frame(3'b110, 1'b0, 1'b0);
    end

    // R3: broken runs just below threshold never commit
    for (int p = 3; p <= 6; p++) begin
      persistCnt = 4'(p);
      curTag = "R3";
      for (int n = 0; n < p; n++) frame(3'b000, 1'b0, 1'b0);
      for (int n = 0; n < p - 1; n++) frame(3'b111, 1'b0, 1'b0);
      frame(3'b010, 1'b0, 1'b0);
      for (int n = 0; n < p - 1; n++) frame(3'b111, 1'b0, 1'b0);
      frame(3'b110, 1'b0, 1'b0);
      for (int n = 0; n < p; n++) frame(3'b110, 1'b0, 1'b0);
      for (int n = 0; n < p - 1; n++) frame(3'b111, 1'b0, 1'b0);
      frame(3'b110, 1'b0, 1'b0);
    end

    // R3: maximum threshold with saturating run
    persistCnt = 4'd15;
    for (int n = 0; n < 18; n++) frame(3'b111, 1'b0, 1'b0);
    for (int n = 0; n < 18; n++) frame(3'b101, 1'b0, 1'b0);

    // R5 R6: both clear windows
    persistCnt = 4'd5;
    for (int f = 0; f < 2; f++) begin
      int win;
      lofFastClr = f[0];
      win = f ? 8 : 24;
      curTag = "R5";
      for (int n = 0; n < 23; n++) frame(3'b000, 1'b1, 1'b0);
      frame(3'b000, 1'b0, 1'b0);
      for (int n = 0; n < 26; n++) frame(3'b000, 1'b1, 1'b0);
      curTag = "R6";
      for (int n = 0; n < win - 1; n++) frame(3'b000, 1'b0, 1'b0);
      frame(3'b000, 1'b1, 1'b0);
      for (int n = 0; n < win + 2; n++) frame(3'b000, 1'b0, 1'b0);
    end

    // R7 R8 R9: loss-of-signal polarity and mask
    for (int a = 0; a < 2; a++)
      for (int i = 0; i < 2; i++)
        for (int l = 0; l < 2; l++) begin
          losActLow = a[0];
          losInh = i[0];
          curTag = i ? "R8" : "R7";
          frame(3'b000, 1'b0, l[0]);
          curTag = "R9";
          frame(3'b000, 1'b0, l[0]);
        end
    losActLow = 1'b0; losInh = 1'b0;

    // R9: RDI request with LAIS only
    persistCnt = 4'd2;
    curTag = "R9";
    frame(3'b111, 1'b0, 1'b0);
    frame(3'b111, 1'b0, 1'b0);

    // R10: inputs move without strobe
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      k2Code = 3'(n);
      oofIn = n[0];
      losPin = n[1];
      losActLow = n[2];
      persistCnt = 4'd0;
      @(negedge clk);
      checkAll("R10");
    end
    losActLow = 1'b0;

    // R1: reset in the middle of an active state
    persistCnt = 4'd1;
    frame(3'b110, 1'b1, 1'b1);
    doReset();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule